// File: doc/BRIEF.md
# Render-Completion Interrupt Register Block

This block sits at the back end of a graphics pipeline and gives the host a small set of 16-bit registers. The pipeline sends it two kinds of event. A token event carries a 16-bit marker value and a flag that asks for an interrupt. A finish pulse reports that a frame has been drawn. Each event sets a sticky status flag. The flag is masked by an enable bit, and the result drives one bit of the host's interrupt cause vector. Software clears a flag by writing a one to that flag's acknowledge bit in the control register.

Through the same bus, software can read the last token value and a few general configuration registers. It can also read four bounding-box coordinates; reading any of them clears a bounding-box-active flag. Finally it can read a set of 32-bit performance counters as pairs of 16-bit halves. A read of a low half captures the matching high half, so the two halves always belong to one sample. The counter values and the box coordinates are computed outside the block and arrive as inputs.

Top module: `render_irq_regs`

## Requirements
- R1: After reset, all configuration registers, both enable bits, both status flags, the token register and the bounding-box-active flag are zero. `irqCause` and `busErr` are low.
- R2: The control register is at byte address 0x0A. A write stores bit 0 (token enable) and bit 1 (finish enable). A read returns those two bits, with bits 15:2 always zero, including acknowledge bits 2 and 3.
- R3: The token register is at 0x0E and is read-only. Every token event loads `tokenValue` into it. The token status flag is set only when `tokenReq` is high with the event.
- R4: A finish pulse sets the finish status flag unconditionally.
- R5: `irqCause` bit 9 equals token status AND token enable, and bit 10 equals finish status AND finish enable. All other bits are zero. Both bits follow a control write or an event one clock later.
- R6: A control write with bit 2 set clears the token status flag, and a write with bit 3 set clears the finish status flag. The same write updates the enables.
- R7: When an acknowledge and a new event of the same kind arrive in the same cycle, the event wins and the status flag stays set.
- R8: Performance counter k has its low half at 0x18+4k and its high half at 0x1A+4k. A low-half read returns bits 15:0 and captures bits 31:16 at that moment. A high-half read returns the captured value, which is zero until the first low-half read.
- R9: Bounding-box coordinate i is read at 0x10+2i. Any such read clears the bounding-box-active flag, `bboxStart` sets it, and a set in the same cycle as a read wins.
- R10: A write to any address other than a configuration register or the control register raises `busErr` for one cycle and changes no state. Reads of unmapped or odd addresses return zero.
- R11: Configuration register j (j < NUM_CFG) is at byte address 2j and is read/write.
- R12: Read data appears on `busRdata` in the cycle after `busRd` is sampled and holds until the next read. `busErr` follows the offending write by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the 16-bit register |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Registered read data |
| busErr | output | 1 | One-cycle flag for a write to a read-only or unmapped address |
| tokenValid | input | 1 | Token event strobe |
| tokenReq | input | 1 | Token event requests an interrupt |
| tokenValue | input | 16 | Token marker value |
| finishPulse | input | 1 | Frame-finish event |
| bboxStart | input | 1 | Sets the bounding-box-active flag |
| bboxCoord | input | 64 | Four 16-bit coordinates, index i at bits 16i+15:16i |
| perfCount | input | 32*NUM_PERF | Counter k at bits 32k+31:32k |
| bboxActive | output | 1 | Bounding-box-active flag |
| irqCause | output | CAUSE_W | Interrupt cause vector, token on bit 9, finish on bit 10 |

## Verification
The hardest case to reach from the ports is a collision in one cycle: an acknowledge write and a fresh event of the same kind, or a box read together with `bboxStart`. The bench drives both collisions directly and also lets them happen in a long random run where events and bus accesses are independent. A second hard case is a torn counter sample. The counter inputs change on every cycle, so a high-half read that did not use the captured value would almost always mismatch the bench's own model.

// File: rtl/rcirq_pkg.sv
package rcirq_pkg;
  // Byte addresses whose positions other logic depends on.
  localparam int CTRL_ADDR  = 10;
  localparam int TOKEN_ADDR = 14;
  localparam int BBOX_BASE  = 16;
  localparam int PERF_BASE  = 24;
  localparam int NUM_BBOX   = 4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CFG, SEL_CTRL, SEL_TOKEN, SEL_BBOX, SEL_PERF_LO, SEL_PERF_HI
  } rdsel_e;

  typedef struct packed {
    logic       rdEn;
    rdsel_e     sel;
    logic [3:0] idx;
    logic       cfgWr;
    logic       ctrlWr;
    logic       err;
  } strobe_t;
endpackage

// File: rtl/rcirq_ctrl.sv
module rcirq_ctrl
  import rcirq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_CFG  = 4,   // 1..5 so the region stays below the control register
  parameter int NUM_PERF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobe_t           strb,
  output logic              busErr
);
  int     addrInt;
  rdsel_e sel;
  logic [3:0] idx;

  assign addrInt = int'(busAddr);

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (!busAddr[0]) begin
      if (addrInt < 2 * NUM_CFG) begin
        sel = SEL_CFG;
        idx = 4'(addrInt >>> 1);
      end else if (addrInt == CTRL_ADDR) begin
        sel = SEL_CTRL;
      end else if (addrInt == TOKEN_ADDR) begin
        sel = SEL_TOKEN;
      end else if (addrInt >= BBOX_BASE && addrInt < BBOX_BASE + 2 * NUM_BBOX) begin
        sel = SEL_BBOX;
        idx = 4'((addrInt - BBOX_BASE) >>> 1);
      end else if (addrInt >= PERF_BASE && addrInt < PERF_BASE + 4 * NUM_PERF) begin
        sel = busAddr[1] ? SEL_PERF_HI : SEL_PERF_LO;
        idx = 4'((addrInt - PERF_BASE) >>> 2);
      end
    end
  end

  always_comb begin
    strb.rdEn   = busRd;
    strb.sel    = sel;
    strb.idx    = idx;
    strb.cfgWr  = busWr && (sel == SEL_CFG);
    strb.ctrlWr = busWr && (sel == SEL_CTRL);
    strb.err    = busWr && !(sel == SEL_CFG || sel == SEL_CTRL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= strb.err;
  end

  AST_ODD_WRITE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr[0] |=> busErr); // R10
  AST_ONE_WRITE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.cfgWr, strb.ctrlWr, strb.err})); // R10
endmodule

// File: rtl/rcirq_datapath.sv
module rcirq_datapath
  import rcirq_pkg::*;
#(
  parameter int NUM_CFG    = 4,
  parameter int NUM_PERF   = 4,
  parameter int CAUSE_W    = 16,
  parameter int TOKEN_BIT  = 9,
  parameter int FINISH_BIT = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [15:0]              busWdata,
  input  logic                     tokenValid,
  input  logic                     tokenReq,
  input  logic [15:0]              tokenValue,
  input  logic                     finishPulse,
  input  logic                     bboxStart,
  input  logic [16*NUM_BBOX-1:0]   bboxCoord,
  input  logic [32*NUM_PERF-1:0]   perfCount,
  output logic [15:0]              busRdata,
  output logic                     bboxActive,
  output logic [CAUSE_W-1:0]       irqCause
);
  localparam int CIDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;
  localparam int PIDX_W = (NUM_PERF > 1) ? $clog2(NUM_PERF) : 1;

  logic [16*NUM_CFG-1:0]  cfgFlat;
  logic [16*NUM_PERF-1:0] shadowFlat;
  logic tokenEn, finishEn, tokenSts, finishSts;
  logic [15:0] tokenReg, rdNext;
  logic tokenSet, tokenAck, finishAck, bboxRd, perfLoRd;

  assign tokenSet  = tokenValid && tokenReq;
  assign tokenAck  = strb.ctrlWr && busWdata[2];
  assign finishAck = strb.ctrlWr && busWdata[3];
  assign bboxRd    = strb.rdEn && (strb.sel == SEL_BBOX);
  assign perfLoRd  = strb.rdEn && (strb.sel == SEL_PERF_LO);

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
    logic [15:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= '0;
      else if (strb.cfgWr && int'(strb.idx) == k) q <= busWdata;
    end
    assign cfgFlat[16*k +: 16] = q;
  end

  for (genvar k = 0; k < NUM_PERF; k++) begin : g_shadow
    logic [15:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= '0;
      else if (perfLoRd && int'(strb.idx) == k) q <= perfCount[32*k+16 +: 16];
    end
    assign shadowFlat[16*k +: 16] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tokenEn    <= 1'b0;
      finishEn   <= 1'b0;
      tokenSts   <= 1'b0;
      finishSts  <= 1'b0;
      tokenReg   <= '0;
      bboxActive <= 1'b0;
    end else begin
      if (strb.ctrlWr) begin
        tokenEn  <= busWdata[0];
        finishEn <= busWdata[1];
      end
      tokenSts   <= tokenSet | (tokenSts & ~tokenAck);
      finishSts  <= finishPulse | (finishSts & ~finishAck);
      if (tokenValid) tokenReg <= tokenValue;
      bboxActive <= bboxStart | (bboxActive & ~bboxRd);
    end
  end

  always_comb begin
    unique case (strb.sel)
      SEL_CFG:     rdNext = cfgFlat[16*int'(strb.idx[CIDX_W-1:0]) +: 16];
      SEL_CTRL:    rdNext = {14'd0, finishEn, tokenEn};
      SEL_TOKEN:   rdNext = tokenReg;
      SEL_BBOX:    rdNext = bboxCoord[16*int'(strb.idx[1:0]) +: 16];
      SEL_PERF_LO: rdNext = perfCount[32*int'(strb.idx[PIDX_W-1:0]) +: 16];
      SEL_PERF_HI: rdNext = shadowFlat[16*int'(strb.idx[PIDX_W-1:0]) +: 16];
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else if (strb.rdEn) busRdata <= rdNext;
  end

  always_comb begin
    irqCause = '0;
    irqCause[TOKEN_BIT]  = tokenSts & tokenEn;
    irqCause[FINISH_BIT] = finishSts & finishEn;
  end

  AST_TOKEN_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    tokenValid |=> tokenReg == $past(tokenValue)); // R3
  AST_EVENT_BEATS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    tokenSet |=> tokenSts); // R7
  AST_FINISH_SETS: assert property (@(posedge clk) disable iff (!rstN)
    finishPulse |=> finishSts); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWr && busWdata[3] && !finishPulse |=> !finishSts); // R6
  AST_BBOX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    bboxRd && !bboxStart |=> !bboxActive); // R9
  AST_ERR_KEEPS_TOKEN: assert property (@(posedge clk) disable iff (!rstN)
    strb.err && !tokenValid |=> $stable(tokenReg)); // R10
endmodule

// File: rtl/render_irq_regs.sv
module render_irq_regs
  import rcirq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_CFG    = 4,
  parameter int NUM_PERF   = 4,
  parameter int CAUSE_W    = 16,
  parameter int TOKEN_BIT  = 9,
  parameter int FINISH_BIT = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWr,
  input  logic                   busRd,
  input  logic [15:0]            busWdata,
  output logic [15:0]            busRdata,
  output logic                   busErr,
  input  logic                   tokenValid,
  input  logic                   tokenReq,
  input  logic [15:0]            tokenValue,
  input  logic                   finishPulse,
  input  logic                   bboxStart,
  input  logic [16*NUM_BBOX-1:0] bboxCoord,
  input  logic [32*NUM_PERF-1:0] perfCount,
  output logic                   bboxActive,
  output logic [CAUSE_W-1:0]     irqCause
);
  strobe_t strb;

  rcirq_ctrl #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG), .NUM_PERF(NUM_PERF)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .strb(strb), .busErr(busErr)
  );

  rcirq_datapath #(
    .NUM_CFG(NUM_CFG), .NUM_PERF(NUM_PERF), .CAUSE_W(CAUSE_W),
    .TOKEN_BIT(TOKEN_BIT), .FINISH_BIT(FINISH_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .tokenValid(tokenValid), .tokenReq(tokenReq), .tokenValue(tokenValue),
    .finishPulse(finishPulse), .bboxStart(bboxStart), .bboxCoord(bboxCoord),
    .perfCount(perfCount), .busRdata(busRdata), .bboxActive(bboxActive),
    .irqCause(irqCause)
  );
endmodule

// File: tb/render_irq_regs_bench.sv
module render_irq_regs_bench;
  localparam int NP = 4;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [15:0] busWdata = '0, busRdata;
  logic busErr;
  logic tokenValid = 1'b0, tokenReq = 1'b0, finishPulse = 1'b0, bboxStart = 1'b0;
  logic [15:0] tokenValue = '0;
  logic [63:0] bboxCoord = '0;
  logic [32*NP-1:0] perfCount = '0;
  logic bboxActive;
  logic [15:0] irqCause;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model
  logic [15:0] mCfg [NC];
  logic [15:0] mShadow [NP];
  logic mTokEn, mFinEn, mTokSts, mFinSts, mBbox;
  logic [15:0] mToken;

  always #10 clk = ~clk;

  render_irq_regs u_render_irq_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .tokenValid(tokenValid), .tokenReq(tokenReq), .tokenValue(tokenValue),
    .finishPulse(finishPulse), .bboxStart(bboxStart), .bboxCoord(bboxCoord),
    .perfCount(perfCount), .bboxActive(bboxActive), .irqCause(irqCause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit isWritable(input logic [7:0] a);
    return (!a[0]) && (a < 8'(2*NC) || a == 8'h0A);
  endfunction

  function automatic string tagOf(input logic [7:0] a);
    if (a[0]) return "R10";
    if (a < 8'(2*NC)) return "R11";
    if (a == 8'h0A) return "R2";
    if (a == 8'h0E) return "R3";
    if (a >= 8'h10 && a < 8'h18) return "R9";
    if (a >= 8'h18 && a < 8'(24 + 4*NP)) return "R8";
    return "R10";
  endfunction

  function automatic logic [15:0] expRead(input logic [7:0] a);
    int i;
    if (a[0]) return 16'h0;
    if (a < 8'(2*NC)) return mCfg[int'(a) / 2];
    if (a == 8'h0A) return {14'd0, mFinEn, mTokEn};
    if (a == 8'h0E) return mToken;
    if (a >= 8'h10 && a < 8'h18) begin
      i = (int'(a) - 16) / 2;
      return bboxCoord[16*i +: 16];
    end
    if (a >= 8'h18 && a < 8'(24 + 4*NP)) begin
      i = (int'(a) - 24) / 4;
      if (a[1]) return mShadow[i];
      return perfCount[32*i +: 16];
    end
    return 16'h0;
  endfunction

  // Drives one cycle starting at a falling edge, updates the model, checks at the next falling edge.
  task automatic step(input logic wr, input logic rd, input logic [7:0] addr,
                      input logic [15:0] wd, input logic tv, input logic tr,
                      input logic [15:0] tval, input logic fin, input logic bs);
    logic [15:0] er;
    logic ee;
    string tg;
    int i;
    busWr = wr; busRd = rd; busAddr = addr; busWdata = wd;
    tokenValid = tv; tokenReq = tr; tokenValue = tval; finishPulse = fin; bboxStart = bs;
    for (int k = 0; k < NP; k++) perfCount[32*k +: 32] = $urandom;
    er = expRead(addr);
    ee = wr && !isWritable(addr);
    tg = tagOf(addr);
    // model next state
    if (wr && isWritable(addr)) begin
      if (addr == 8'h0A) begin
        mTokEn = wd[0]; mFinEn = wd[1];
      end else mCfg[int'(addr) / 2] = wd;
    end
    mTokSts = (tv && tr) || (mTokSts && !(wr && addr == 8'h0A && wd[2]));
    mFinSts = fin || (mFinSts && !(wr && addr == 8'h0A && wd[3]));
    if (tv) mToken = tval;
    mBbox = bs || (mBbox && !(rd && !addr[0] && addr >= 8'h10 && addr < 8'h18));
    if (rd && !addr[0] && addr >= 8'h18 && addr < 8'(24 + 4*NP) && !addr[1]) begin
      i = (int'(addr) - 24) / 4;
      mShadow[i] = perfCount[32*i + 16 +: 16];
    end
    @(posedge clk);
    @(negedge clk);
    chk("R5", 32'(irqCause), 32'({5'd0, mFinSts && mFinEn, mTokSts && mTokEn, 9'd0}));
    chk("R10", 32'(busErr), 32'(ee));
    chk("R9", 32'(bboxActive), 32'(mBbox));
    if (rd) chk({tg, " R12"}, 32'(busRdata), 32'(er));
  endtask

  task automatic idle();
    step(0, 0, 8'h00, 16'h0, 0, 0, 16'h0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NC; k++) mCfg[k] = '0;
    for (int k = 0; k < NP; k++) mShadow[k] = '0;
    mTokEn = 0; mFinEn = 0; mTokSts = 0; mFinSts = 0; mBbox = 0; mToken = '0;
    for (int k = 0; k < 4; k++) bboxCoord[16*k +: 16] = 16'($urandom);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1", 32'(irqCause), 0);
    chk("R1", 32'(bboxActive), 0);
    chk("R1", 32'(busErr), 0);
    step(0, 1, 8'h0A, 16'h0, 0, 0, 16'h0, 0, 0);
    chk("R1", 32'(busRdata), 0);
    step(0, 1, 8'h0E, 16'h0, 0, 0, 16'h0, 0, 0);
    chk("R1", 32'(busRdata), 0);

    // R11 config read/write
    step(1, 0, 8'h04, 16'hBEEF, 0, 0, 16'h0, 0, 0);
    step(0, 1, 8'h04, 16'h0, 0, 0, 16'h0, 0, 0);
    chk("R11", 32'(busRdata), 32'hBEEF);

    // R2 ack bits read as zero, enables stored
    step(1, 0, 8'h0A, 16'hFFFF, 0, 0, 16'h0, 0, 0);
    step(0, 1, 8'h0A, 16'h0, 0, 0, 16'h0, 0, 0);
    chk("R2", 32'(busRdata), 32'h3);

    // R3 token without request: value latched, no interrupt
    step(0, 0, 8'h00, 16'h0, 1, 0, 16'h1234, 0, 0);
    chk("R3", 32'(irqCause), 0);
    step(0, 1, 8'h0E, 16'h0, 0, 0, 16'h0, 0, 0);
    chk("R3", 32'(busRdata), 32'h1234);

    // R7 ack collides with new token request: flag stays
    step(0, 0, 8'h00, 16'h0, 1, 1, 16'h5678, 0, 0);
    step(1, 0, 8'h0A, 16'h0007, 1, 1, 16'h9ABC, 0, 0);
    chk("R7", 32'(irqCause[9]), 1);
    // R6 plain ack clears
    step(1, 0, 8'h0A, 16'h0007, 0, 0, 16'h0, 0, 0);
    chk("R6", 32'(irqCause[9]), 0);

    // R4 finish pulse
    step(0, 0, 8'h00, 16'h0, 0, 0, 16'h0, 1, 0);
    chk("R4", 32'(irqCause[10]), 1);
    step(1, 0, 8'h0A, 16'h000B, 0, 0, 16'h0, 0, 0);
    chk("R6", 32'(irqCause[10]), 0);

    // R10 write to read-only token register leaves it unchanged
    step(1, 0, 8'h0E, 16'hDEAD, 0, 0, 16'h0, 0, 0);
    chk("R10", 32'(busErr), 1);
    idle();
    chk("R10", 32'(busErr), 0);
    step(0, 1, 8'h0E, 16'h0, 0, 0, 16'h0, 0, 0);
    chk("R10", 32'(busRdata), 32'h9ABC);

    // R8 torn-read protection: counters change every cycle
    step(0, 1, 8'h1C, 16'h0, 0, 0, 16'h0, 0, 0);
    idle();
    step(0, 1, 8'h1E, 16'h0, 0, 0, 16'h0, 0, 0);
    chk("R8", 32'(busRdata), 32'(mShadow[1]));

    // R9 set and read in the same cycle: set wins; then read clears
    step(0, 1, 8'h12, 16'h0, 0, 0, 16'h0, 0, 1);
    chk("R9", 32'(bboxActive), 1);
    step(0, 1, 8'h16, 16'h0, 0, 0, 16'h0, 0, 0);
    chk("R9", 32'(bboxActive), 0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      logic wr, rd;
      int op;
      op = $urandom_range(0, 3);
      wr = (op == 1);
      rd = (op >= 2);
      if ($urandom_range(0, 1) == 0) a = 8'($urandom_range(0, 47));
      else case ($urandom_range(0, 4))
        0: a = 8'h0A;
        1: a = 8'h0E;
        2: a = 8'(2 * $urandom_range(0, NC - 1));
        3: a = 8'(16 + 2 * $urandom_range(0, 3));
        default: a = 8'(24 + 2 * $urandom_range(0, 2*NP - 1));
      endcase
      step(wr, rd, a, 16'($urandom), $urandom_range(0, 4) == 0, $urandom_range(0, 1) == 1,
           16'($urandom), $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule